// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block sits between a simple word-oriented request port and a four-bank, 16-bit synchronous DRAM. After reset it runs the power-up sequence on its own and loads the device mode register. From then on it turns each accepted request into the row-open, column-access and row-close commands the device needs. It keeps one open row per bank, so a request that lands in an already open row goes straight to the column command. A timer forces a periodic auto refresh between requests.

The request port uses a valid/ready handshake. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold the request fields stable while `req_valid` is high and `req_ready` is low. The controller applies back-pressure by keeping `req_ready` low in four cases: during initialisation, while a transfer is in flight, during refresh, and in any cycle in which a refresh is owed. Read data returns in request order as a single-cycle `rd_valid` strobe, and the requester cannot stall it.

All device-facing pins come straight from registers. The command code is {cs_n, ras_n, cas_n, we_n}: 0111 no-op, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 auto refresh, 0000 mode register load. The burst length is fixed at one word.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is asserted and until initialisation ends, `req_ready` is 0. After the power-up delay the controller issues, in order, a precharge with A10=1, two auto refreshes, and a mode register load. No activate, read or write is issued before that load.
- R2: The mode register load drives bank bits 0, A3:A0 = 0000 (burst of one, sequential), and A6:A4 equal to the CAS latency: 3 when `cl3_sel`=1 and 2 when `cl3_sel`=0.
- R3: `req_addr` is split as bank = bits 21:20, row = bits 19:8, column = bits 7:0. An activate carries the bank and the row on A11:A0. A read or write carries the bank and the column on A7:A0, with A10=0 so the row stays open.
- R4: A request whose row is already open in its bank is served with the column command alone, with no activate and no precharge.
- R5: A request to a bank with a different open row first precharges that bank alone (A10=0). The activate follows at least T_RP cycles later, and the column command at least T_RCD cycles after the activate.
- R6: A request to a closed bank issues an activate and no precharge.
- R7: `rd_valid` pulses for one cycle per read. `rd_data` is the value on `sd_dq_in` at the rising edge that comes CAS latency edges after the edge at which the read command was presented. Reads return in request order.
- R8: A write drives `sd_dq_oe`=1 only in the write command cycle, with `sd_dq_out` equal to the request data. `sd_dqm[0]` = !`req_be[0]` masks bits 7:0 and `sd_dqm[1]` = !`req_be[1]` masks bits 15:8.
- R9: An auto refresh is issued only when all banks are closed. If any bank is open, a precharge with A10=1 comes first, at least T_RP cycles earlier. No activate follows a refresh by fewer than T_RC cycles.
- R10: Once a refresh is owed, it takes priority over a waiting request as soon as the current transfer ends. Under continuous requests, consecutive refreshes are never more than REF_INTERVAL plus one worst-case transfer apart.
- R11: `req_ready` drops in the cycle after a request is accepted and stays low until the controller is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cl3_sel | input | 1 | CAS latency select: 1 = three cycles, 0 = two; hold stable after reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 for bits 7:0 |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 16 | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Multiplexed address, A10 is the precharge flag |
| sd_dqm | output | 2 | Byte data masks |
| sd_dq_out | output | 16 | Write data to the device |
| sd_dq_oe | output | 1 | Output enable for the data bus |
| sd_dq_in | input | 16 | Data from the device |

## Verification
A refresh falling due and a request waiting at the port can coincide in the same idle cycle. The refresh must win. If a row is open it must be closed first, and the request must wait. The bench uses a short refresh interval and keeps `req_valid` asserted almost every cycle with random hits and misses, so the refresh deadline often arrives while a request is pending. A behavioural device model at the pins judges every case: each refresh must find all banks closed, the gap between refreshes must stay within the bound, every later activate must respect T_RC, and each read value must match a scoreboard built from the request stream.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_ACT  = 4'b0011,
    CMD_WR   = 4'b0100,
    CMD_RD   = 4'b0101,
    CMD_NOP  = 4'b0111
  } sdc_cmd_e;

  typedef enum logic [3:0] {
    ST_PWR, ST_IPRE, ST_IREF, ST_MRS, ST_IDLE,
    ST_PRE, ST_ACT, ST_COL, ST_RPRE, ST_REF, ST_WAIT
  } sdc_state_e;
endpackage

// File: rtl/sdc_ref_timer.sv
module sdc_ref_timer #(
  parameter int INTERVAL = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic due
);
  localparam int W = $clog2(INTERVAL + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run || ack) begin
      cnt <= '0;
      due <= 1'b0;
    end else if (cnt == W'(INTERVAL - 1)) begin
      due <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sdc_bank_rows.sv
module sdc_bank_rows #(
  parameter int BA_W  = 2,
  parameter int ROW_W = 12,
  localparam int BANKS = 1 << BA_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            act_en,
  input  logic                            pre_en,
  input  logic                            pre_all,
  input  logic [BA_W-1:0]                 bank,
  input  logic [ROW_W-1:0]                row,
  output logic [BANKS-1:0]                open_vec,
  output logic [BANKS-1:0][ROW_W-1:0]     row_tab
);
  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_vec[g] <= 1'b0;
        row_tab[g]  <= '0;
      end else if (act_en && bank == BA_W'(g)) begin
        open_vec[g] <= 1'b1;
        row_tab[g]  <= row;
      end else if (pre_en && (pre_all || bank == BA_W'(g))) begin
        open_vec[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdc_rd_pipe.sv
module sdc_rd_pipe #(
  parameter int DW     = 16,
  parameter int MAX_CL = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          cl3,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic [MAX_CL-1:0] sr;
  logic              tap;

  assign tap = cl3 ? sr[MAX_CL-1] : sr[MAX_CL-2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr       <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      sr       <= {sr[MAX_CL-2:0], issue};
      rd_valid <= tap;
      if (tap) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdc_pkg::*;
#(
  parameter int BA_W     = 2,
  parameter int ROW_W    = 12,
  parameter int COL_W    = 8,
  parameter int DW       = 16,
  parameter int AP_BIT   = 10,
  parameter int T_PWRUP  = 13300,
  parameter int T_RP     = 3,
  parameter int T_RCD    = 3,
  parameter int T_RC     = 9,
  parameter int T_MRD    = 2,
  parameter int T_WR     = 2,
  parameter int REF_INTERVAL = 2000,
  localparam int AW      = BA_W + ROW_W + COL_W,
  localparam int MASK_W  = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cl3_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [MASK_W-1:0] req_be,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [MASK_W-1:0] sd_dqm,
  output logic [DW-1:0]     sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DW-1:0]     sd_dq_in
);
  localparam int BANKS = 1 << BA_W;
  localparam int CW    = $clog2(T_PWRUP + T_RC + T_RP + 4);
  localparam logic [ROW_W-1:0] AP_MASK = ROW_W'(1) << AP_BIT;

  sdc_state_e state, ret;
  sdc_cmd_e   cmd_q;
  logic [CW-1:0]     cnt;
  logic              init_ref, init_done;
  logic              l_write;
  logic [BA_W-1:0]   l_bank;
  logic [ROW_W-1:0]  l_row;
  logic [COL_W-1:0]  l_col;
  logic [DW-1:0]     l_data;
  logic [MASK_W-1:0] l_be;

  logic [BA_W-1:0]   q_bank;
  logic [ROW_W-1:0]  q_row;
  logic [BANKS-1:0]  open_vec;
  logic [BANKS-1:0][ROW_W-1:0] row_tab;
  logic              ref_due;

  assign q_bank = req_addr[AW-1 -: BA_W];
  assign q_row  = req_addr[COL_W +: ROW_W];
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign req_ready = (state == ST_IDLE) && !ref_due;

  sdc_bank_rows #(.BA_W(BA_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n),
    .act_en(state == ST_ACT),
    .pre_en(state == ST_PRE || state == ST_IPRE || state == ST_RPRE),
    .pre_all(state != ST_PRE),
    .bank(l_bank), .row(l_row),
    .open_vec(open_vec), .row_tab(row_tab)
  );

  sdc_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst_n(rst_n), .run(init_done),
    .ack(state == ST_REF), .due(ref_due)
  );

  sdc_rd_pipe #(.DW(DW), .MAX_CL(3)) u_rdp (
    .clk(clk), .rst_n(rst_n), .issue(cmd_q == CMD_RD), .cl3(cl3_sel),
    .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_PWR;  ret <= ST_IDLE;
      cnt <= CW'(T_PWRUP - 1);
      cmd_q <= CMD_NOP; sd_ba <= '0; sd_a <= '0;
      sd_dqm <= '0; sd_dq_out <= '0; sd_dq_oe <= 1'b0;
      init_ref <= 1'b0; init_done <= 1'b0;
      l_write <= 1'b0; l_bank <= '0; l_row <= '0; l_col <= '0;
      l_data <= '0; l_be <= '0;
    end else begin
      cmd_q <= CMD_NOP; sd_dq_oe <= 1'b0; sd_dqm <= '0;
      case (state)
        ST_PWR: if (cnt == '0) state <= ST_IPRE; else cnt <= cnt - 1'b1;
        ST_IPRE, ST_RPRE: begin
          cmd_q <= CMD_PRE; sd_a <= AP_MASK;
          cnt <= CW'(T_RP - 2); state <= ST_WAIT;
          ret <= (state == ST_IPRE) ? ST_IREF : ST_REF;
        end
        ST_IREF: begin
          cmd_q <= CMD_REF; init_ref <= 1'b1;
          cnt <= CW'(T_RC - 2); state <= ST_WAIT;
          ret <= init_ref ? ST_MRS : ST_IREF;
        end
        ST_MRS: begin
          cmd_q <= CMD_MRS; sd_ba <= '0;
          sd_a <= ROW_W'({(cl3_sel ? 3'd3 : 3'd2), 4'b0000});
          init_done <= 1'b1;
          cnt <= CW'(T_MRD - 2); state <= ST_WAIT; ret <= ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_due) begin
            state <= (|open_vec) ? ST_RPRE : ST_REF;
          end else if (req_valid) begin
            l_write <= req_write; l_bank <= q_bank; l_row <= q_row;
            l_col <= req_addr[COL_W-1:0]; l_data <= req_wdata; l_be <= req_be;
            if (open_vec[q_bank] && row_tab[q_bank] == q_row) state <= ST_COL;
            else if (open_vec[q_bank])                         state <= ST_PRE;
            else                                               state <= ST_ACT;
          end
        end
        ST_PRE: begin
          cmd_q <= CMD_PRE; sd_ba <= l_bank; sd_a <= '0;
          cnt <= CW'(T_RP - 2); state <= ST_WAIT; ret <= ST_ACT;
        end
        ST_ACT: begin
          cmd_q <= CMD_ACT; sd_ba <= l_bank; sd_a <= l_row;
          cnt <= CW'(T_RCD - 2); state <= ST_WAIT; ret <= ST_COL;
        end
        ST_COL: begin
          cmd_q <= l_write ? CMD_WR : CMD_RD;
          sd_ba <= l_bank; sd_a <= ROW_W'(l_col);
          if (l_write) begin
            sd_dq_oe <= 1'b1; sd_dq_out <= l_data; sd_dqm <= ~l_be;
            cnt <= CW'(T_WR - 2);
          end else begin
            cnt <= cl3_sel ? CW'(2) : CW'(1);
          end
          state <= ST_WAIT; ret <= ST_IDLE;
        end
        ST_REF: begin
          cmd_q <= CMD_REF;
          cnt <= CW'(T_RC - 2); state <= ST_WAIT; ret <= ST_IDLE;
        end
        ST_WAIT: if (cnt == '0) state <= ret; else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdc_checks.sv
module sdc_checks
  import sdc_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BA_W  = 2,
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cl3_sel,
  input logic             req_ready,
  input logic             rd_valid,
  input logic             sd_dq_oe,
  input logic [3:0]       cmd,
  input logic [BA_W-1:0]  ba,
  input logic [ROW_W-1:0] a,
  input logic [BANKS-1:0] open_vec
);
  logic             mrs_seen;
  logic [BANKS-1:0] prev_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mrs_seen  <= 1'b0;
      prev_open <= '0;
    end else begin
      if (cmd == CMD_MRS) mrs_seen <= 1'b1;
      prev_open <= open_vec;
    end
  end

  a_r1_ready_after_mrs: assert property (@(posedge clk) disable iff (!rst_n)
    !mrs_seen |-> !req_ready);

  a_r6_act_on_closed_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |-> (!prev_open[ba] && open_vec[ba]));

  a_r3_col_on_open_row: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> (open_vec[ba] && !a[10]));

  a_r9_ref_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |-> (open_vec == '0));

  a_r8_oe_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (cmd == CMD_WR));

  a_r7_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (cl3_sel ? $past(cmd == CMD_RD, 4) : $past(cmd == CMD_RD, 3)));
endmodule

bind sdram_seq_ctrl sdc_checks #(.BANKS(BANKS), .BA_W(BA_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cl3_sel(cl3_sel), .req_ready(req_ready),
  .rd_valid(rd_valid), .sd_dq_oe(sd_dq_oe), .cmd(cmd_q), .ba(sd_ba),
  .a(sd_a), .open_vec(open_vec)
);

// File: tb/sdram_seq_ctrl_test.sv
module sdram_seq_ctrl_test;
  localparam int T_PWRUP = 30, REF_INT = 150, T_RP = 3, T_RCD = 3, T_RC = 9;
  localparam int SLACK = 30;

  logic clk = 0, rst_n = 0, cl3 = 1;
  logic req_valid = 0, req_write = 0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [15:0] rd_data, sd_dq_out, sd_dq_in;
  logic [1:0]  sd_ba, sd_dqm;
  logic [11:0] sd_a;

  sdram_seq_ctrl #(.T_PWRUP(T_PWRUP), .REF_INTERVAL(REF_INT), .T_RP(T_RP),
                   .T_RCD(T_RCD), .T_RC(T_RC)) uut (
    .clk(clk), .rst_n(rst_n), .cl3_sel(cl3), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dflt(logic [21:0] ad);
    return ad[15:0] ^ {ad[21:16], 10'h2B5};
  endfunction

  function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] d, logic [1:0] keep);
    return {keep[1] ? old[15:8] : d[15:8], keep[0] ? old[7:0] : d[7:0]};
  endfunction

  // ---------------- device model at the pins ----------------
  logic [15:0] smem [int];
  logic [15:0] md0, md1, md2;
  assign sd_dq_in = cl3 ? md2 : md1;
  int cyc = 0, ref_time, gap_base, last_pre_any, act_cnt = 0, pre_cnt = 0, ref_cnt = 0;
  int last_pre [4], last_act [4];
  bit bopen [4];
  logic [11:0] brow [4];
  bit mrs_done, init_pre;
  int init_refs;
  int rd_cyc_q [$];

  always @(posedge clk) begin
    logic [3:0]  c;
    logic [21:0] ad;
    logic [15:0] old, rv;
    cyc++;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    rv = 16'hDEAD;
    if (!rst_n) begin
      mrs_done = 0; init_pre = 0; init_refs = 0; ref_time = -100; last_pre_any = -100;
      for (int i = 0; i < 4; i++) begin bopen[i] = 0; last_pre[i] = -100; last_act[i] = -100; end
      rd_cyc_q.delete();
    end else begin
      case (c)
        4'b0010: begin
          if (!mrs_done) begin chk(sd_a[10], "R1", sd_a[10], 1); init_pre = 1; end
          if (sd_a[10]) begin
            for (int i = 0; i < 4; i++) begin bopen[i] = 0; last_pre[i] = cyc; end
          end else begin
            bopen[sd_ba] = 0; last_pre[sd_ba] = cyc; pre_cnt++;
          end
          last_pre_any = cyc;
        end
        4'b0001: begin
          if (!mrs_done) begin
            chk(init_pre, "R1", init_pre, 1); init_refs++;
          end else begin
            chk(cyc - gap_base <= REF_INT + SLACK, "R10", cyc - gap_base, REF_INT + SLACK);
            gap_base = cyc; ref_cnt++;
          end
          chk(!(bopen[0] | bopen[1] | bopen[2] | bopen[3]), "R9", 1, 0);
          chk(cyc - last_pre_any >= T_RP, "R9", cyc - last_pre_any, T_RP);
          ref_time = cyc;
        end
        4'b0000: begin
          chk(init_refs == 2, "R1", init_refs, 2);
          chk(sd_a[6:0] == {(cl3 ? 3'd3 : 3'd2), 4'b0000} && sd_ba == 0, "R2",
              {sd_ba, sd_a}, {(cl3 ? 3'd3 : 3'd2), 4'b0000});
          mrs_done = 1; gap_base = cyc;
        end
        4'b0011: begin
          chk(mrs_done, "R1", mrs_done, 1);
          chk(!bopen[sd_ba], "R6", bopen[sd_ba], 0);
          chk(cyc - last_pre[sd_ba] >= T_RP, "R5", cyc - last_pre[sd_ba], T_RP);
          chk(cyc - ref_time >= T_RC, "R9", cyc - ref_time, T_RC);
          bopen[sd_ba] = 1; brow[sd_ba] = sd_a; last_act[sd_ba] = cyc; act_cnt++;
        end
        4'b0100, 4'b0101: begin
          chk(mrs_done && bopen[sd_ba] && !sd_a[10], "R3", {bopen[sd_ba], sd_a[10]}, 2);
          chk(cyc - last_act[sd_ba] >= T_RCD, "R5", cyc - last_act[sd_ba], T_RCD);
          ad = {sd_ba, brow[sd_ba], sd_a[7:0]};
          old = smem.exists(int'(ad)) ? smem[int'(ad)] : dflt(ad);
          if (c == 4'b0100) begin
            chk(sd_dq_oe, "R8", sd_dq_oe, 1);
            smem[int'(ad)] = merge(old, sd_dq_out, sd_dqm);
          end else begin
            rv = old; rd_cyc_q.push_back(cyc);
          end
        end
        default: ;
      endcase
    end
    md0 <= rv; md1 <= md0; md2 <= md1;
  end

  // ---------------- scoreboard ----------------
  logic [15:0] refm [int];
  logic [15:0] exp_q [$];

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R7", rd_data, 16'hFFFF);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rd_data === e, "R7", rd_data, e);
      end
      if (rd_cyc_q.size() != 0) begin
        int k;
        k = rd_cyc_q.pop_front();
        chk(cyc - k == (cl3 ? 3 : 2), "R7", cyc - k, cl3 ? 3 : 2);
      end
    end
  end

  task automatic do_req(bit w, logic [21:0] ad, logic [15:0] d, logic [1:0] be);
    logic [15:0] old;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = ad; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    old = refm.exists(int'(ad)) ? refm[int'(ad)] : dflt(ad);
    if (w) refm[int'(ad)] = merge(old, d, ~be);
    else exp_q.push_back(old);
    @(negedge clk);
    chk(!req_ready, "R11", req_ready, 0);
    req_valid = 0;
  endtask

  task automatic drain();
    repeat (10) @(negedge clk);
  endtask

  task automatic start(bit c3);
    rst_n = 0; cl3 = c3;
    repeat (3) @(negedge clk);
    chk(!req_ready, "R1", req_ready, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    rst_n = 1;
    while (!req_ready) @(negedge clk);
    chk(mrs_done && init_refs == 2, "R1", init_refs, 2);
  endtask

  task automatic rand_ops(int n);
    for (int i = 0; i < n; i++) begin
      logic [21:0] ad;
      ad = {2'($urandom % 4), 12'($urandom % 3), 8'($urandom % 4)};
      do_req(1'($urandom % 2), ad, 16'($urandom), 2'($urandom % 4));
    end
  endtask

  initial begin
    int a0, p0, c0, r0;
    void'($urandom(32'd77));
    start(1);
    // R6: closed bank opens with an activate only
    a0 = act_cnt; p0 = pre_cnt;
    do_req(1, {2'd1, 12'd5, 8'd3}, 16'h1234, 2'b11); drain();
    chk(act_cnt == a0 + 1 && pre_cnt == p0, "R6", act_cnt - a0, 1);
    // R4: row hit goes straight to the column command
    a0 = act_cnt; p0 = pre_cnt;
    do_req(0, {2'd1, 12'd5, 8'd3}, 0, 0); drain();
    chk(act_cnt == a0 && pre_cnt == p0, "R4", act_cnt - a0, 0);
    // R8: only the low byte lane written
    do_req(1, {2'd1, 12'd5, 8'd9}, 16'hABCD, 2'b01);
    do_req(0, {2'd1, 12'd5, 8'd9}, 0, 0); drain();
    // R5: miss closes just that bank then reopens
    a0 = act_cnt; p0 = pre_cnt;
    do_req(0, {2'd1, 12'd7, 8'd3}, 0, 0); drain();
    chk(act_cnt == a0 + 1 && pre_cnt == p0 + 1, "R5", pre_cnt - p0, 1);
    // R10: sustained load across many refresh periods
    c0 = cyc; r0 = ref_cnt;
    rand_ops(250); drain();
    chk(ref_cnt - r0 >= (cyc - c0) / (REF_INT + SLACK), "R10", ref_cnt - r0,
        (cyc - c0) / (REF_INT + SLACK));
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    // second run with two-cycle CAS latency (R2, R7)
    start(0);
    rand_ops(120); drain();
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WD", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule